// File: doc/BRIEF.md
# Shared Display Bus Arbiter

This block sits between a processor bus and a memory bus that the processor shares with a DMA engine. When the processor starts a bus cycle, a region decode tells the block whether the cycle targets the shared memory and custom registers or a private target such as ROM or I/O. A shared cycle is held waiting by keeping the active-low acknowledge high. The wait lasts while the DMA engine holds the buses and until the colour-clock phase is the one in which shared cycles must finish. A private cycle is acknowledged at once, whatever the DMA engine is doing.

The processor clock runs at exactly twice the colour clock and is synchronous to it, so the colour-clock phase input alternates on every processor clock. While a shared cycle is granted, the block drives the enable of the isolation drivers that join the processor bus to the shared buses. At every other time those drivers stay off, so a processor that has not been granted cannot disturb the shared buses.

Top module: `shbus_arb`

## Requirements
- R1: A synchronous active-high `rst` leaves `ack_n` at 1 and `drv_en` at 0 on the edge after it is sampled high.
- R2: A shared cycle (`cpu_as_n` low with `sel_shared` at 1) keeps `ack_n` at 1 and `drv_en` at 0 until it is granted.
- R3: A grant never happens on an edge where `dma_req_n` is sampled low. This holds even when the DMA request and the processor strobe first appear in the same cycle.
- R4: A grant happens only on an edge where `cc_phase` equals `GRANT_PHASE` (default 1). `ack_n` therefore falls one clock after a cycle presenting that phase, and the wait is as short as that rule allows.
- R5: A private cycle (`sel_shared` at 0) drives `ack_n` to 0 on the edge after the strobe is sampled low, whatever the value of `dma_req_n`. `drv_en` stays 0 throughout such a cycle.
- R6: `ack_n` returns to 1 and `drv_en` to 0 on the edge that samples `cpu_as_n` high.
- R7: `drv_en` is 1 only during a granted shared cycle, and in that cycle `ack_n` is 0.
- R8: A shared cycle whose strobe is withdrawn before the grant returns the block to idle and produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, twice the colour clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| sel_shared | input | 1 | 1 when the cycle targets shared memory or custom registers |
| dma_req_n | input | 1 | DMA bus request, active low; low means the DMA engine owns the buses |
| cc_phase | input | 1 | Current colour-clock phase |
| ack_n | output | 1 | Data acknowledge to the processor, active low |
| drv_en | output | 1 | Enable of the isolation bus drivers |

## Verification
The acknowledge latency is checked with cycles that start in both colour-clock phases. This separates a phase-aligned grant from one that ignores the phase. DMA requests lasting zero to five cycles, raised together with the strobe, show that ownership and phase alignment combine and that the DMA request wins a tie. Private cycles started while the DMA engine is active show that ROM and I/O traffic is never stalled. Directed cases cover reset in the middle of a granted cycle and a strobe withdrawn before the grant.

// File: rtl/shbus_arb.sv
module shbus_arb #(
  parameter bit GRANT_PHASE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_as_n,
  input  logic sel_shared,
  input  logic dma_req_n,
  input  logic cc_phase,
  output logic ack_n,
  output logic drv_en
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GRANT, S_LOCAL} st_t;
  st_t st;

  logic grant_ok;
  assign grant_ok = dma_req_n && (cc_phase == GRANT_PHASE);

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:
          if (!cpu_as_n) begin
            if (!sel_shared) st <= S_LOCAL;
            else if (grant_ok) st <= S_GRANT;
            else st <= S_WAIT;
          end
        S_WAIT:
          if (cpu_as_n) st <= S_IDLE;
          else if (grant_ok) st <= S_GRANT;
        default:
          if (cpu_as_n) st <= S_IDLE;
      endcase
    end
  end

  assign ack_n  = !(st == S_GRANT || st == S_LOCAL);
  assign drv_en = (st == S_GRANT);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ack_n && !drv_en));

  a_r3_no_grant_under_dma: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> $past(dma_req_n));

  a_r4_grant_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> ($past(cc_phase) == GRANT_PHASE));

  a_r5_local_fast: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_as_n) && !sel_shared) |=> (!ack_n && !drv_en));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_as_n) |=> (ack_n && !drv_en));

  a_r7_drv_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> $past(!cpu_as_n && sel_shared));

endmodule

// File: tb/shbus_arb_tb_top.sv
module shbus_arb_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_as_n = 1'b1;
  logic sel_shared = 1'b0;
  logic dma_req_n = 1'b1;
  logic cc_phase = 1'b0;
  logic ack_n, drv_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shbus_arb #(.GRANT_PHASE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cpu_as_n(cpu_as_n), .sel_shared(sel_shared),
    .dma_req_n(dma_req_n), .cc_phase(cc_phase), .ack_n(ack_n), .drv_en(drv_en)
  );

  // {shared, start phase, dma cycles[3:0], expected latency in edges[3:0]}
  localparam logic [9:0] VEC [0:8] = '{
    {1'b1, 1'b1, 4'd0, 4'd1},
    {1'b1, 1'b0, 4'd0, 4'd2},
    {1'b1, 1'b1, 4'd1, 4'd3},
    {1'b1, 1'b1, 4'd2, 4'd3},
    {1'b1, 1'b0, 4'd3, 4'd4},
    {1'b1, 1'b0, 4'd4, 4'd6},
    {1'b0, 1'b0, 4'd3, 4'd1},
    {1'b0, 1'b1, 4'd0, 4'd1},
    {1'b1, 1'b1, 4'd5, 4'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    cc_phase = ~cc_phase;
  endtask

  task automatic run_vec(input logic [9:0] v);
    logic sh, st;
    int dc, lat;
    logic last_ph, last_dma;
    sh = v[9]; st = v[8]; dc = int'(v[7:4]); lat = int'(v[3:0]);
    cpu_as_n = 1'b1; dma_req_n = 1'b1;
    adv();
    while (~cc_phase != st) adv();
    adv();
    cpu_as_n = 1'b0; sel_shared = sh; dma_req_n = (dc > 0) ? 1'b0 : 1'b1;
    last_ph = cc_phase; last_dma = dma_req_n;
    for (int k = 1; k <= 12; k++) begin
      adv();
      if (k < lat) begin
        chk(ack_n == 1'b1, sh ? "R2 ack held while waiting" : "R5 local ack", ack_n, 1);
        chk(drv_en == 1'b0, "R2 drivers off while waiting", drv_en, 0);
      end else begin
        chk(ack_n == 1'b0, sh ? "R4 ack latency" : "R5 local ack latency", ack_n, 0);
        chk(drv_en == sh, "R7 driver enable on grant", drv_en, sh);
        if (sh) begin
          chk(last_ph == 1'b1, "R4 granted in required phase", last_ph, 1);
          chk(last_dma == 1'b1, "R3 no grant under DMA", last_dma, 1);
        end
        break;
      end
      dma_req_n = (k < dc) ? 1'b0 : 1'b1;
      last_ph = cc_phase; last_dma = dma_req_n;
    end
    adv();
    chk(ack_n == 1'b0, "R6 ack held while strobe low", ack_n, 0);
    cpu_as_n = 1'b1;
    adv();
    chk(ack_n == 1'b1, "R6 ack released", ack_n, 1);
    chk(drv_en == 1'b0, "R6 drivers released", drv_en, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) adv();
    rst = 1'b0;
    adv();
    chk(ack_n == 1'b1 && drv_en == 1'b0, "R1 reset state", {ack_n, drv_en}, 2);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R8: withdraw strobe while DMA holds the buses
    adv();
    cpu_as_n = 1'b0; sel_shared = 1'b1; dma_req_n = 1'b0;
    adv(); adv();
    cpu_as_n = 1'b1; dma_req_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      adv();
      chk(ack_n == 1'b1 && drv_en == 1'b0, "R8 withdrawn cycle idle", {ack_n, drv_en}, 2);
    end

    // R1: reset in the middle of a granted cycle
    cpu_as_n = 1'b0; sel_shared = 1'b1;
    adv(); adv(); adv();
    chk(drv_en == 1'b1, "R7 granted before reset", drv_en, 1);
    rst = 1'b1;
    adv();
    chk(ack_n == 1'b1 && drv_en == 1'b0, "R1 reset mid-cycle", {ack_n, drv_en}, 2);
    rst = 1'b0; cpu_as_n = 1'b1;
    adv();
    chk(ack_n == 1'b1 && drv_en == 1'b0, "R1 idle after reset", {ack_n, drv_en}, 2);

    summary();
  end

endmodule